// File: doc/BRIEF.md
# Multi-Source Sync Strobe Selector

This block hands out synchronization strobes to the functions of a receiver datapath. Each consumer has a 3-bit select register of its own and takes its strobe from one of eight sources: four external sync pins, the terminal count of a free-running period counter, a software one-shot, a constant low, or a constant high. Each output is registered, so a strobe follows its selected source by a fixed latency.

The period counter is also one of the targets. Its reset strobe is chosen through the same 8-way select as every other consumer, so the counter can be realigned to an external pin, to software, or to its own terminal count. Target 0 is the counter reset. Target 1 drives the dedicated sync output pin. The remaining targets go to datapath functions such as FIFO pointer reset, power meters, AGC timers, freeze and accumulator clear, and NCO reset.

Configuration arrives through a single-cycle write port. Address `i` (for `i < NUM_TGT`) is the select of target `i`. Address `NUM_TGT` is the counter period. Address `NUM_TGT+1` fires the one-shot.

Top module: `sync_select_net`

## Requirements
- R1: Each sync pin is registered on the rising clock edge before use. A pin level present before edge k shows on a strobe selecting that pin after edge k+1, and not after edge k.
- R2: Select codes 000, 001, 010 and 011 route sync_in[0], [1], [2] and [3] respectively; the other three pins have no effect on that strobe.
- R3: Select code 100 routes the counter terminal count. The counter runs 0..P and wraps, so with the period register at P the strobe is high for one cycle every P+1 cycles; with P = 0 it is high on every cycle.
- R4: Select code 110 holds a strobe low and code 111 holds it high, whatever the pins do.
- R5: Select code 101 routes the one-shot. Writing a 1 in data bit 0 at address NUM_TGT+1 raises the strobe for exactly one cycle, starting after the second rising edge following the accepted write; the trigger clears itself.
- R6: Target i has its own select at address i (data bits [2:0]); target 1 also drives sync_out_pin; changing one target's select changes no other strobe.
- R7: A high target-0 strobe zeroes the counter on the next edge, taking priority over wrap and increment. Terminal count is still emitted on a cycle where both occur. With target 0 set to code 100, the terminal count period becomes P+2.
- R8: Synchronous reset clears all strobes, the counter and any pending one-shot, and sets every select to 110.
- R9: The period register is written at address NUM_TGT with the low CNT_W data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 4 | External sync pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Register write data |
| sync_stb | output | NUM_TGT | Registered per-target sync strobes |
| sync_out_pin | output | 1 | Dedicated sync output (target 1) |

## Verification
A pin strobe is due two edges after the pin is driven. A one-shot strobe is due two edges after the write is accepted, and a select change first shows one edge after its write. The bench drives every input on the falling edge and samples exactly at those falling edges. It also checks the falling edge one cycle earlier, where the strobe must still be low. Terminal count is judged by the spacing between successive highs, and the counter realignment is judged by counting edges from a pin pulse through the registered counter-reset strobe to the next terminal count.

// File: rtl/sync_select_net.sv
module sync_select_net #(
  parameter int NUM_TGT = 8,
  parameter int CNT_W   = 8,
  parameter int ADDR_W  = 4,
  parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        sync_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NUM_TGT-1:0] sync_stb,
  output logic              sync_out_pin
);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(NUM_TGT);
  localparam logic [ADDR_W-1:0] A_SHOT   = ADDR_W'(NUM_TGT + 1);
  localparam logic [2:0] CODE_OFF = 3'b110;

  logic [3:0]               pin_q;
  logic [NUM_TGT-1:0][2:0]  sel_q;
  logic [CNT_W-1:0]         cnt_q, period_q;
  logic                     shot_q;
  logic                     tc;
  logic [7:0]               src;

  assign tc  = (cnt_q == period_q);
  assign src = {1'b1, 1'b0, shot_q, tc, pin_q};
  assign sync_out_pin = sync_stb[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q    <= '0;
      shot_q   <= 1'b0;
      period_q <= PERIOD_RST;
      cnt_q    <= '0;
    end else begin
      pin_q  <= sync_in;
      shot_q <= wr_en && (wr_addr == A_SHOT) && wr_data[0];
      if (wr_en && wr_addr == A_PERIOD)
        period_q <= wr_data;
      if (sync_stb[0])
        cnt_q <= '0;
      else if (cnt_q >= period_q)
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[i]    <= CODE_OFF;
        sync_stb[i] <= 1'b0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(i))
          sel_q[i] <= wr_data[2:0];
        sync_stb[i] <= src[sel_q[i]];
      end
    end
  end
endmodule

module sync_select_net_chk #(
  parameter int NUM_TGT = 8,
  parameter int CNT_W   = 8,
  parameter int ADDR_W  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       wr_addr,
  input logic [CNT_W-1:0]        wr_data,
  input logic [3:0]              pin_q,
  input logic [NUM_TGT-1:0][2:0] sel_q,
  input logic [CNT_W-1:0]        cnt_q,
  input logic [CNT_W-1:0]        period_q,
  input logic                    shot_q,
  input logic                    tc,
  input logic [NUM_TGT-1:0]      sync_stb
);
  for (genvar i = 0; i < NUM_TGT; i++) begin : g_a
    AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (rst)
      sel_q[i] == 3'b110 |=> !sync_stb[i]); // R4
    AST_ON_IS_HIGH: assert property (@(posedge clk) disable iff (rst)
      sel_q[i] == 3'b111 |=> sync_stb[i]); // R4
    AST_PIN_ROUTE: assert property (@(posedge clk) disable iff (rst)
      !sel_q[i][2] |=> sync_stb[i] == $past(pin_q[sel_q[i][1:0]])); // R2
  end

  AST_TC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (tc && period_q != '0) |=> (!tc || period_q == '0)); // R3
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    sync_stb[0] |=> cnt_q == '0); // R7
  AST_SHOT_SELFCLR: assert property (@(posedge clk) disable iff (rst)
    (shot_q && !(wr_en && wr_addr == ADDR_W'(NUM_TGT + 1) && wr_data[0])) |=> !shot_q); // R5
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (sync_stb == '0 && cnt_q == '0 && !shot_q)); // R8
endmodule

bind sync_select_net sync_select_net_chk #(
  .NUM_TGT(NUM_TGT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pin_q(pin_q), .sel_q(sel_q), .cnt_q(cnt_q), .period_q(period_q),
  .shot_q(shot_q), .tc(tc), .sync_stb(sync_stb)
);

// File: tb/tb_sync_select_net.sv
module tb_sync_select_net;
  localparam int NT = 8;
  localparam int CW = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] sync_in = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NT-1:0] sync_stb;
  logic sync_out_pin;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_select_net #(.NUM_TGT(NT), .CNT_W(CW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_stb(sync_stb), .sync_out_pin(sync_out_pin));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = CW'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic period_check(input int t, input int p, input string req);
    int last, highs;
    last = -1; highs = 0;
    for (int k = 0; k < 4 * (p + 1) + 6; k++) begin
      @(negedge clk);
      if (sync_stb[t]) begin
        if (last >= 0) check(req, 32'(k - last), 32'(p + 1));
        last = k; highs++;
      end
    end
    check({req, " count"}, 32'(highs >= 3), 32'd1);
  endtask

  initial begin
    tick(3);
    sync_in = 4'hF;
    tick(1);
    check("R8 strobes after reset", 32'(sync_stb), 0);
    rst = 1'b0;
    tick(3);
    check("R8 selects off after reset", 32'(sync_stb), 0);
    check("R8 out pin low", 32'(sync_out_pin), 0);

    for (int t = 0; t < NT; t++) begin
      for (int c = 0; c < 4; c++) begin
        logic [3:0] base;
        base = ~(4'b1 << c);
        wr(t, c);
        sync_in = base;
        tick(2);
        check("R2 other pins ignored", 32'(sync_stb), 0);
        sync_in = 4'hF;
        @(negedge clk);
        sync_in = base;
        check("R1 pin not yet through", 32'(sync_stb), 0);
        @(negedge clk);
        check("R2 pin routed", 32'(sync_stb), 32'(1 << t));
        if (t == 1) check("R6 out pin follows target 1", 32'(sync_out_pin), 1);
        @(negedge clk);
        check("R1 pulse one cycle", 32'(sync_stb), 0);
      end
      sync_in = 4'h0;
      wr(t, 7);
      tick(1);
      check("R4 forced high", 32'(sync_stb), 32'(1 << t));
      sync_in = 4'hF;
      wr(t, 6);
      tick(1);
      check("R4 forced low", 32'(sync_stb), 0);
      wr(t, 5);
      tick(2);
      check("R5 no shot without write", 32'(sync_stb), 0);
      wr(NT + 1, 1);
      check("R5 shot not early", 32'(sync_stb), 0);
      @(negedge clk);
      check("R5 shot fires", 32'(sync_stb), 32'(1 << t));
      @(negedge clk);
      check("R5 shot self clears", 32'(sync_stb), 0);
      wr(t, 6);
      sync_in = 4'h0;
    end

    begin
      int ps[4] = '{0, 1, 3, 6};
      for (int j = 0; j < 4; j++) begin
        wr(NT, ps[j]);
        wr(2 + j, 4);
        period_check(2 + j, ps[j], "R3/R9 terminal count spacing");
        wr(2 + j, 6);
      end
    end

    wr(NT, 7);
    wr(0, 0);
    wr(2, 4);
    tick(3);
    sync_in = 4'b0001;
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk);
      sync_in = 4'b0000;
      if (k >= 4 && k <= 10) check("R7 counter realigned, no tc", 32'(sync_stb[2]), 0);
      if (k == 11) check("R7 tc after realign", 32'(sync_stb[2]), 1);
    end

    wr(NT, 3);
    wr(0, 4);
    period_check(2, 4, "R7 self resync period");

    wr(NT, 0);
    wr(0, 7);
    tick(2);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R7 tc kept while reset wins", 32'(sync_stb[2]), 1);
    end

    wr(3, 7);
    sync_in = 4'hF;
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    check("R8 mid-run reset clears", 32'(sync_stb), 0);
    tick(2);
    check("R8 selects back to off", 32'(sync_stb), 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule